// File: doc/BRIEF.md
# Transceiver Operating State Controller

This block sits between a link-layer controller and a dual-speed (full-speed / high-speed) serial bus front-end. A 2-bit mode request picks one of four operating states. The selected state decides whether the D+ pull-up is connected and whether the high-speed terminations are on. It also decides what two shared control inputs mean: they act as full-speed driver controls in the two lower states and as high-speed transmit controls in the two upper states.

Every change of state, and the release of power-on reset, starts a termination calibration sequence. A fixed settling delay comes first, then a fixed calibration window. Receive-inactive is raised for the length of the window, and the high-speed terminations are held off during it. A second, link-side reset input holds the whole data interface idle while it is low. It also realigns the phase of the word strobe, so that the first strobe after release falls at a known cycle.

The delays are counted in reference-clock cycles. The defaults assume a 30 MHz reference: 120 cycles for the delay (4 µs) and 60 cycles for the window (2 µs).

Top module: `xcvr_state_ctrl`

## Requirements
- R1: `op_state` takes the value of `mode` at the clock edge that samples it, and shows it from that edge on. The encoding is 0 = disconnected, 1 = full-speed, 2 = high-speed, 3 = chirp. Power-on reset gives 0.
- R2: `pullup_en` is 1 in states 1 and 3, and 0 in states 0 and 2.
- R3: In states 0 and 1, `pin_ctl_a` drives `fs_oe` and `hs_tx_valid` is 0. In states 2 and 3, `pin_ctl_a` drives `hs_tx_valid` and `fs_oe` is 0.
- R4: In states 0 and 1, `pin_ctl_b` drives `fs_se0` and `hs_stuff_en` is 0. In states 2 and 3, `pin_ctl_b` drives `hs_stuff_en` and `fs_se0` is 0.
- R5: Take the edge that captures a new state as edge 0. `rx_inactive` rises after edge WAIT_CYC, stays high for exactly CAL_CYC cycles, and falls after edge WAIT_CYC+CAL_CYC.
- R6: After power-on reset is released, the first clock edge counts as edge 1 of the delay. `rx_inactive` is therefore high from edge WAIT_CYC to edge WAIT_CYC+CAL_CYC. It is 0 while reset is asserted.
- R7: A state change during the settling delay or during the window restarts the delay from edge 0. A change during the window drops `rx_inactive` at the capturing edge.
- R8: `hs_term_en` is 1 only in state 2 and only while `rx_inactive` is 0.
- R9: While `link_rst_n` is 0, `fs_oe`, `fs_se0`, `hs_tx_valid`, `hs_stuff_en` and `rx_valid` are all 0, whatever the state and inputs.
- R10: `rx_valid` equals `phy_rx_valid` when `link_rst_n` is 1 and `rx_inactive` is 0. Otherwise it is 0.
- R11: `word_strobe` is 0 while `link_rst_n` is 0. It is 1 in the cycle after the first edge following release, and from then on once every WORD_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| mode | input | 2 | Requested operating state |
| link_rst_n | input | 1 | Link-side reset, active low, synchronous |
| pin_ctl_a | input | 1 | Shared control: FS output enable or HS transmit valid |
| pin_ctl_b | input | 1 | Shared control: FS force-SE0 or HS bit-stuff enable |
| phy_rx_valid | input | 1 | Receive-valid from the receive path |
| op_state | output | 2 | Current operating state |
| pullup_en | output | 1 | D+ pull-up connect |
| hs_term_en | output | 1 | High-speed termination enable |
| rx_inactive | output | 1 | Calibration window in progress |
| fs_oe | output | 1 | Full-speed driver output enable |
| fs_se0 | output | 1 | Full-speed force single-ended zero |
| hs_tx_valid | output | 1 | High-speed transmit valid |
| hs_stuff_en | output | 1 | High-speed bit-stuff enable |
| rx_valid | output | 1 | Gated receive-valid |
| word_strobe | output | 1 | Word-clock phase strobe |

## Verification
The state register and every output derived from it settle one edge after a new mode is presented. The routed pins, `rx_valid` and the link-reset gating are combinational from their inputs and settle within the same cycle. The calibration edges fall WAIT_CYC+1 and WAIT_CYC+CAL_CYC+1 edges after the mode is applied, and one edge earlier after power-on release. Inputs are driven at the falling edge and outputs are sampled there after a counted number of edges. Each window boundary is probed on both sides, one cycle before and at the expected change.

// File: rtl/xsc_pkg.sv
`timescale 1ns/1ps
package xsc_pkg;

   typedef enum logic [1:0] {
      ST_DISC  = 2'd0,
      ST_FS    = 2'd1,
      ST_HS    = 2'd2,
      ST_CHIRP = 2'd3
   } op_state_t;

   typedef enum logic [1:0] {
      PH_SETTLE = 2'd0,
      PH_CAL    = 2'd1,
      PH_DONE   = 2'd2
   } cal_phase_t;

   typedef struct packed {
      logic fs_oe;
      logic fs_se0;
      logic hs_txv;
      logic hs_stuff;
   } pin_route_t;

   function automatic logic is_hs_group(op_state_t s);
      return s[1];
   endfunction

endpackage

// File: rtl/xsc_mode_track.sv
`timescale 1ns/1ps
module xsc_mode_track
   import xsc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic [1:0] mode,
   output op_state_t state_q,
   output logic      restart
);

   op_state_t req;

   assign req     = op_state_t'(mode);
   assign restart = (req != state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_DISC;
      end else if (restart) begin
         state_q <= req;
      end
   end

endmodule

// File: rtl/xsc_cal_timer.sv
`timescale 1ns/1ps
module xsc_cal_timer
   import xsc_pkg::*;
#(
   parameter int WAIT_CYC = 120,
   parameter int CAL_CYC  = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic in_cal
);

   localparam int MAX_CYC = (WAIT_CYC > CAL_CYC) ? WAIT_CYC : CAL_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);
   localparam logic [CNT_W-1:0] CAL_LAST  = CNT_W'(CAL_CYC - 1);

   if (WAIT_CYC < 2) begin : g_bad_wait
      $error("xsc_cal_timer: WAIT_CYC must be at least 2");
   end
   if (CAL_CYC < 1) begin : g_bad_cal
      $error("xsc_cal_timer: CAL_CYC must be at least 1");
   end

   cal_phase_t       phase;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_SETTLE;
         cnt   <= '0;
      end else if (restart) begin
         phase <= PH_SETTLE;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_SETTLE: begin
               if (cnt == WAIT_LAST) begin
                  phase <= PH_CAL;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_CAL: begin
               if (cnt == CAL_LAST) begin
                  phase <= PH_DONE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               phase <= PH_DONE;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign in_cal = (phase == PH_CAL);

endmodule

// File: rtl/xsc_pin_router.sv
`timescale 1ns/1ps
module xsc_pin_router
   import xsc_pkg::*;
(
   input  op_state_t  state_q,
   input  logic       link_rst_n,
   input  logic       pin_a,
   input  logic       pin_b,
   output pin_route_t route
);

   logic hs_grp;
   logic live;

   assign hs_grp = is_hs_group(state_q);
   assign live   = link_rst_n;

   always_comb begin
      route          = '0;
      route.fs_oe    = live & ~hs_grp & pin_a;
      route.fs_se0   = live & ~hs_grp & pin_b;
      route.hs_txv   = live &  hs_grp & pin_a;
      route.hs_stuff = live &  hs_grp & pin_b;
   end

endmodule

// File: rtl/xsc_word_phase.sv
`timescale 1ns/1ps
module xsc_word_phase #(
   parameter int WORD_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic link_rst_n,
   output logic strobe
);

   localparam int PH_W = (WORD_DIV > 2) ? $clog2(WORD_DIV) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(WORD_DIV - 1);
   localparam bit  POW2 = ((WORD_DIV & (WORD_DIV - 1)) == 0);

   if (WORD_DIV < 2) begin : g_bad_div
      $error("xsc_word_phase: WORD_DIV must be at least 2");
   end

   logic [PH_W-1:0] ph;

   if (POW2) begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           ph <= '0;
         else if (!link_rst_n) ph <= '0;
         else                  ph <= ph + 1'b1;
      end
   end else begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              ph <= '0;
         else if (!link_rst_n)    ph <= '0;
         else if (ph == PH_LAST)  ph <= '0;
         else                     ph <= ph + 1'b1;
      end
   end

   assign strobe = (ph == PH_LAST);

endmodule

// File: rtl/xcvr_state_ctrl.sv
`timescale 1ns/1ps
module xcvr_state_ctrl
   import xsc_pkg::*;
#(
   parameter int WAIT_CYC = 120,
   parameter int CAL_CYC  = 60,
   parameter int WORD_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       link_rst_n,
   input  logic       pin_ctl_a,
   input  logic       pin_ctl_b,
   input  logic       phy_rx_valid,
   output logic [1:0] op_state,
   output logic       pullup_en,
   output logic       hs_term_en,
   output logic       rx_inactive,
   output logic       fs_oe,
   output logic       fs_se0,
   output logic       hs_tx_valid,
   output logic       hs_stuff_en,
   output logic       rx_valid,
   output logic       word_strobe
);

   op_state_t  state_q;
   logic       restart;
   logic       in_cal;
   pin_route_t route;

   xsc_mode_track u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .state_q (state_q),
      .restart (restart)
   );

   xsc_cal_timer #(
      .WAIT_CYC (WAIT_CYC),
      .CAL_CYC  (CAL_CYC)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .in_cal  (in_cal)
   );

   xsc_pin_router u_router (
      .state_q    (state_q),
      .link_rst_n (link_rst_n),
      .pin_a      (pin_ctl_a),
      .pin_b      (pin_ctl_b),
      .route      (route)
   );

   xsc_word_phase #(
      .WORD_DIV (WORD_DIV)
   ) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .link_rst_n (link_rst_n),
      .strobe     (word_strobe)
   );

   assign op_state    = state_q;
   assign pullup_en   = (state_q == ST_FS) || (state_q == ST_CHIRP);
   assign hs_term_en  = (state_q == ST_HS) && !in_cal;
   assign rx_inactive = in_cal;
   assign fs_oe       = route.fs_oe;
   assign fs_se0      = route.fs_se0;
   assign hs_tx_valid = route.hs_txv;
   assign hs_stuff_en = route.hs_stuff;
   assign rx_valid    = phy_rx_valid & link_rst_n & ~in_cal;

endmodule

// File: rtl/xsc_checker.sv
`timescale 1ns/1ps
module xsc_checker #(
   parameter int CAL_CYC = 60
) (
   input logic       clk,
   input logic       rst_n,
   input logic       link_rst_n,
   input logic [1:0] op_state,
   input logic       pullup_en,
   input logic       hs_term_en,
   input logic       rx_inactive,
   input logic       fs_oe,
   input logic       fs_se0,
   input logic       hs_tx_valid,
   input logic       hs_stuff_en,
   input logic       rx_valid
);

   localparam int RUN_W = $clog2(CAL_CYC + 2);

   logic [RUN_W-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           run <= '0;
      else if (rx_inactive) run <= run + 1'b1;
      else                  run <= '0;
   end

   AST_DISC_NO_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
      (op_state == 2'd0) |-> !pullup_en); // R2

   AST_FS_PINS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(fs_oe && hs_tx_valid) && !(fs_se0 && hs_stuff_en)); // R3

   AST_STATE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (op_state != $past(op_state)) |-> !rx_inactive); // R7

   AST_CAL_RUN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      rx_inactive |-> (run < RUN_W'(CAL_CYC))); // R5

   AST_TERM_OFF_CAL: assert property (@(posedge clk) disable iff (!rst_n)
      rx_inactive |-> !hs_term_en); // R8

   AST_LINK_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !link_rst_n |-> !(fs_oe || fs_se0 || hs_tx_valid || hs_stuff_en || rx_valid)); // R9

   AST_RXV_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      rx_inactive |-> !rx_valid); // R10

endmodule

bind xcvr_state_ctrl xsc_checker #(.CAL_CYC(CAL_CYC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .link_rst_n  (link_rst_n),
   .op_state    (op_state),
   .pullup_en   (pullup_en),
   .hs_term_en  (hs_term_en),
   .rx_inactive (rx_inactive),
   .fs_oe       (fs_oe),
   .fs_se0      (fs_se0),
   .hs_tx_valid (hs_tx_valid),
   .hs_stuff_en (hs_stuff_en),
   .rx_valid    (rx_valid)
);

// File: tb/xcvr_state_ctrl_bench.sv
`timescale 1ns/1ps
module xcvr_state_ctrl_bench;

   localparam int WAIT_CYC = 120;
   localparam int CAL_CYC  = 60;
   localparam int NVEC     = 8;

   // {mode[1:0], link_rst_n, pin_a, pin_b, fs_oe, fs_se0, hs_txv, hs_stuff, pullup}
   localparam logic [9:0] VEC [NVEC] = '{
      10'b00_1_1_0_1_0_0_0_0,
      10'b00_1_0_1_0_1_0_0_0,
      10'b01_1_1_1_1_1_0_0_1,
      10'b10_1_1_0_0_0_1_0_0,
      10'b10_1_0_1_0_0_0_1_0,
      10'b11_1_1_1_0_0_1_1_1,
      10'b11_0_1_1_0_0_0_0_1,
      10'b01_0_1_1_0_0_0_0_1
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] mode;
   logic       link_rst_n;
   logic       pin_ctl_a;
   logic       pin_ctl_b;
   logic       phy_rx_valid;
   logic [1:0] op_state;
   logic       pullup_en, hs_term_en, rx_inactive;
   logic       fs_oe, fs_se0, hs_tx_valid, hs_stuff_en, rx_valid, word_strobe;

   int checks   = 0;
   int failures = 0;
   int cyc      = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   xcvr_state_ctrl #(
      .WAIT_CYC (WAIT_CYC),
      .CAL_CYC  (CAL_CYC),
      .WORD_DIV (2)
   ) u_xcvr_state_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode         (mode),
      .link_rst_n   (link_rst_n),
      .pin_ctl_a    (pin_ctl_a),
      .pin_ctl_b    (pin_ctl_b),
      .phy_rx_valid (phy_rx_valid),
      .op_state     (op_state),
      .pullup_en    (pullup_en),
      .hs_term_en   (hs_term_en),
      .rx_inactive  (rx_inactive),
      .fs_oe        (fs_oe),
      .fs_se0       (fs_se0),
      .hs_tx_valid  (hs_tx_valid),
      .hs_stuff_en  (hs_stuff_en),
      .rx_valid     (rx_valid),
      .word_strobe  (word_strobe)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n        = 1'b0;
      link_rst_n   = 1'b0;
      mode         = 2'd0;
      pin_ctl_a    = 1'b0;
      pin_ctl_b    = 1'b0;
      phy_rx_valid = 1'b0;
      step(3);

      // reset state
      chk("R1", "reset op_state", 32'(op_state), 32'd0);
      chk("R2", "reset pullup", 32'(pullup_en), 32'd0);
      chk("R6", "reset rx_inactive", 32'(rx_inactive), 32'd0);
      chk("R8", "reset term", 32'(hs_term_en), 32'd0);

      // power-on calibration window
      rst_n = 1'b1;
      step(WAIT_CYC - 1);
      chk("R6", "por before window", 32'(rx_inactive), 32'd0);
      step(1);
      chk("R6", "por window start", 32'(rx_inactive), 32'd1);
      step(CAL_CYC - 1);
      chk("R6", "por window last", 32'(rx_inactive), 32'd1);
      step(1);
      chk("R6", "por window end", 32'(rx_inactive), 32'd0);

      // routing table: R1 R2 R3 R4 R9
      for (int i = 0; i < NVEC; i++) begin
         mode       = VEC[i][9:8];
         link_rst_n = VEC[i][7];
         pin_ctl_a  = VEC[i][6];
         pin_ctl_b  = VEC[i][5];
         step(1);
         chk("R1", $sformatf("vec%0d state", i), 32'(op_state), 32'(VEC[i][9:8]));
         chk("R3", $sformatf("vec%0d pin_a", i), 32'({fs_oe, hs_tx_valid}),
             32'({VEC[i][4], VEC[i][2]}));
         chk("R4", $sformatf("vec%0d pin_b", i), 32'({fs_se0, hs_stuff_en}),
             32'({VEC[i][3], VEC[i][1]}));
         chk("R2", $sformatf("vec%0d pullup", i), 32'(pullup_en), 32'(VEC[i][0]));
      end

      // settle, then timed change into high-speed: R5 R8 R10
      link_rst_n = 1'b1;
      step(WAIT_CYC + CAL_CYC + 10);
      mode = 2'd2;
      step(1);
      chk("R1", "state hs", 32'(op_state), 32'd2);
      chk("R8", "term on before window", 32'(hs_term_en), 32'd1);
      step(WAIT_CYC - 1);
      chk("R5", "before window", 32'(rx_inactive), 32'd0);
      phy_rx_valid = 1'b1;
      step(1);
      chk("R5", "window start", 32'(rx_inactive), 32'd1);
      chk("R8", "term off in window", 32'(hs_term_en), 32'd0);
      chk("R10", "rx_valid blocked", 32'(rx_valid), 32'd0);
      step(CAL_CYC - 1);
      chk("R5", "window last", 32'(rx_inactive), 32'd1);
      step(1);
      chk("R5", "window end", 32'(rx_inactive), 32'd0);
      chk("R8", "term back on", 32'(hs_term_en), 32'd1);
      chk("R10", "rx_valid passes", 32'(rx_valid), 32'd1);
      link_rst_n = 1'b0;
      pin_ctl_a  = 1'b1;
      pin_ctl_b  = 1'b1;
      #1;
      chk("R9", "link reset idle", 32'({fs_oe, fs_se0, hs_tx_valid, hs_stuff_en, rx_valid}),
          32'd0);
      step(1);
      link_rst_n   = 1'b1;
      phy_rx_valid = 1'b0;
      pin_ctl_a    = 1'b0;
      pin_ctl_b    = 1'b0;

      // restart while the delay is pending: R7
      mode = 2'd3;
      step(60);
      mode = 2'd1;
      step(61);
      chk("R7", "old window suppressed", 32'(rx_inactive), 32'd0);
      step(WAIT_CYC - 61);
      chk("R7", "restarted before window", 32'(rx_inactive), 32'd0);
      step(1);
      chk("R7", "restarted window start", 32'(rx_inactive), 32'd1);

      // restart while the window runs: R7 R2
      step(10);
      mode = 2'd0;
      step(1);
      chk("R7", "window cut by change", 32'(rx_inactive), 32'd0);
      chk("R2", "disc pullup off", 32'(pullup_en), 32'd0);
      step(WAIT_CYC - 1);
      chk("R7", "new delay before window", 32'(rx_inactive), 32'd0);
      step(1);
      chk("R7", "new window start", 32'(rx_inactive), 32'd1);

      // word strobe realignment: R11
      link_rst_n = 1'b0;
      step(3);
      chk("R11", "strobe held in reset", 32'(word_strobe), 32'd0);
      link_rst_n = 1'b1;
      step(1);
      chk("R11", "first strobe", 32'(word_strobe), 32'd1);
      step(1);
      chk("R11", "strobe gap", 32'(word_strobe), 32'd0);
      step(1);
      chk("R11", "second strobe", 32'(word_strobe), 32'd1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule